// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive request lines and presents one winning request to a processor. The output is a priority level together with a vector number. Each source carries an 8-bit control byte, and that byte is also the source's priority level. A control byte of zero switches the source off.

A small register bus sets the block up. It uses a byte offset, read and write strobes, and 32-bit data. Through it software can program the control bytes, mask or unmask sources (whole 32-bit halves, or one bit at a time through indexed commands), force requests, observe the live request lines and read the current vector.

Arbitration is a linear priority pick. The highest control byte among the eligible sources wins, and a tie goes to the higher source index. The level/vector pair is captured in one register stage, so the two values always belong to the same decision.

Top module: `prio_intc`

## Requirements
- R1: A source is eligible when (request line OR force bit) is 1, its control byte is nonzero, and its mask bit is 0.
- R2: Among eligible sources the largest control byte wins. On equal bytes the higher source index wins.
- R3: With a winner at index i, the vector is 64+i and the level is that source's control byte. With no eligible source the vector is 24 and the level is 0.
- R4: Level and vector are registered outputs. They reflect a change on the request lines at the next rising clock edge, and a register write one edge after the write edge.
- R5: A write to offset 0x40+n stores wr_data[7:0] as the control byte of source n. A read of that offset returns the byte zero-extended. A zero byte disables the source.
- R6: A write to 0x08 replaces mask bits 63:32 and a write to 0x0C replaces mask bits 31:0; the other half is left unchanged. Writes to 0x00, 0x04 and to unmapped offsets change no state.
- R7: A write to 0x1C sets all mask bits when wr_data[6] is 1. Otherwise it sets only the mask bit indexed by wr_data[5:0].
- R8: A write to 0x1D clears all mask bits when wr_data[6] is 1. Otherwise it clears only the mask bit indexed by wr_data[5:0].
- R9: Reads return combinationally while rd_en is high:
  - 0x00/0x04: request lines 63:32 and 31:0.
  - 0x08/0x0C: the mask halves.
  - 0x10/0x14: the force halves; writes to these offsets replace the corresponding force half.
  - 0xE0: the current vector.
  - Any other offset: zero.
- R10: After reset the mask is all ones; force and all control bytes are zero, the level is 0 and the vector is 24.
- R11: The pending state of each source follows its request line level with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when rd_en is low |
| irq_level | output | 8 | Winning priority level, 0 when idle |
| irq_vector | output | 8 | Winning vector, 24 when idle |

## Verification
The bench builds the block with its default parameters: 64 sources, 8-bit levels, 8-bit offsets and 32-bit data. These values make the full address map reachable, including both mask halves and the top source 63 at vector 127.

With them the bench exercises:
- ties between equal levels;
- a disabled source alongside enabled ones;
- forced requests;
- every mask command form.

The register-stage delay is checked against irq_in changes and against bus writes separately.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int SRC_N   = 64;
  localparam int LVL_W   = 8;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int VEC_W   = 8;
  localparam int IDX_W   = $clog2(SRC_N);

  localparam logic [VEC_W-1:0] VEC_IDLE = 8'd24;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'd64;

  localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FRC_HI  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FRC_LO  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MSET    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MCLR    = 8'h1D;
  localparam logic [ADDR_W-1:0] OFS_VEC     = 8'hE0;

  // vector number for a decision
  function automatic logic [VEC_W-1:0] make_vector(input logic found,
                                                   input logic [IDX_W-1:0] idx);
    return found ? (VEC_BASE + VEC_W'(idx)) : VEC_IDLE;
  endfunction

  // true when the offset falls in the control-byte window
  function automatic logic is_ctl_ofs(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W] == 2'b01;
  endfunction
endpackage

// File: rtl/ic_regs.sv
module ic_regs
  import ic_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int LW = LVL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [N-1:0]    mask_o,
  output logic [N-1:0]    force_o,
  output logic [N*LW-1:0] ctl_o
);
  localparam int IW   = $clog2(N);
  localparam int HALF = N / 2;

  logic [N-1:0]    mask_q, force_q;
  logic [N*LW-1:0] ctl_q;
  logic [IW-1:0]   bit_sel;

  assign bit_sel = wr_data[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      force_q <= '0;
      ctl_q   <= '0;
    end else if (wr_en) begin
      if (is_ctl_ofs(addr)) begin
        ctl_q[addr[IW-1:0]*LW +: LW] <= wr_data[LW-1:0];
      end else begin
        unique case (addr)
          OFS_MASK_HI: mask_q[N-1:HALF]  <= wr_data[HALF-1:0];
          OFS_MASK_LO: mask_q[HALF-1:0]  <= wr_data[HALF-1:0];
          OFS_FRC_HI:  force_q[N-1:HALF] <= wr_data[HALF-1:0];
          OFS_FRC_LO:  force_q[HALF-1:0] <= wr_data[HALF-1:0];
          OFS_MSET: begin
            if (wr_data[6]) mask_q <= '1;
            else            mask_q[bit_sel] <= 1'b1;
          end
          OFS_MCLR: begin
            if (wr_data[6]) mask_q <= '0;
            else            mask_q[bit_sel] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign mask_o  = mask_q;
  assign force_o = force_q;
  assign ctl_o   = ctl_q;
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
  parameter int N  = 64,
  parameter int LW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    active,
  input  logic [N*LW-1:0] ctl,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [LW-1:0]   lvl
);
  // ascending scan with >= so ties land on the higher index
  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '0;
    for (int i = 0; i < N; i++) begin
      if (active[i] && ctl[i*LW +: LW] >= lvl) begin
        found = 1'b1;
        idx   = IW'(i);
        lvl   = ctl[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/ic_outreg.sv
module ic_outreg
  import ic_pkg::*;
#(
  parameter int LW = LVL_W,
  parameter int IW = IDX_W,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          found,
  input  logic [IW-1:0] idx,
  input  logic [LW-1:0] lvl,
  output logic [LW-1:0] level_q,
  output logic [VW-1:0] vector_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      vector_q <= VEC_IDLE;
    end else begin
      level_q  <= found ? lvl : '0;
      vector_q <= make_vector(found, idx);
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import ic_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int LW = LVL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] irq_level,
  output logic [VW-1:0] irq_vector
);
  localparam int IW   = $clog2(N);
  localparam int HALF = N / 2;

  logic [N-1:0]    mask_q, force_q, enable_w, active_w;
  logic [N*LW-1:0] ctl_q;
  logic            win_found;
  logic [IW-1:0]   win_idx;
  logic [LW-1:0]   win_lvl;

  ic_regs #(.N(N), .LW(LW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .mask_o(mask_q), .force_o(force_q), .ctl_o(ctl_q)
  );

  for (genvar g = 0; g < N; g++) begin : g_en
    assign enable_w[g] = |ctl_q[g*LW +: LW];
  end

  assign active_w = (irq_in | force_q) & enable_w & ~mask_q;

  ic_arbiter #(.N(N), .LW(LW)) u_arb (
    .active(active_w), .ctl(ctl_q),
    .found(win_found), .idx(win_idx), .lvl(win_lvl)
  );

  ic_outreg #(.LW(LW), .IW(IW), .VW(VW)) u_out (
    .clk(clk), .rst_n(rst_n), .found(win_found), .idx(win_idx), .lvl(win_lvl),
    .level_q(irq_level), .vector_q(irq_vector)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (is_ctl_ofs(addr)) begin
        rd_data = DW'(ctl_q[addr[IW-1:0]*LW +: LW]);
      end else begin
        unique case (addr)
          OFS_PEND_HI: rd_data = DW'(irq_in[N-1:HALF]);
          OFS_PEND_LO: rd_data = DW'(irq_in[HALF-1:0]);
          OFS_MASK_HI: rd_data = DW'(mask_q[N-1:HALF]);
          OFS_MASK_LO: rd_data = DW'(mask_q[HALF-1:0]);
          OFS_FRC_HI:  rd_data = DW'(force_q[N-1:HALF]);
          OFS_FRC_LO:  rd_data = DW'(force_q[HALF-1:0]);
          OFS_VEC:     rd_data = DW'(irq_vector);
          default:     rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import ic_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int LW = LVL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int VW = VEC_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic [N-1:0]  mask_q,
  input logic [LW-1:0] irq_level,
  input logic [VW-1:0] irq_vector
);
  localparam int HALF = N / 2;

  assert_idle_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) == (irq_vector == VEC_IDLE));

  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_vector >= VEC_BASE));

  assert_mset_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MSET && wr_data[6]) |=> (mask_q == '1));

  assert_mclr_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MCLR && wr_data[6]) |=> (mask_q == '0));

  assert_mask_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK_HI) |=> $stable(mask_q[HALF-1:0]));

  assert_pend_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_PEND_HI || addr == OFS_PEND_LO)) |=> $stable(mask_q));
endmodule

bind prio_intc prio_intc_chk #(.N(N), .LW(LW), .AW(AW), .DW(DW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .mask_q(mask_q), .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq_level, irq_vector;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  // stimulus: request pattern, expected level, expected vector
  typedef struct packed { logic [63:0] irq; logic [7:0] lvl; logic [7:0] vec; } vec_t;
  localparam vec_t TABLE [8] = '{
    '{64'h0,                              8'd0, 8'd24},
    '{64'h8,                              8'd5, 8'd67},
    '{64'h408,                            8'd5, 8'd74},
    '{64'h0010_0408,                      8'd7, 8'd84},
    '{64'h0000_0100_0000_0000,            8'd0, 8'd24},
    '{64'h8000_0000_0000_0001,            8'd2, 8'd64},
    '{64'h8000_0000_0000_0000,            8'd1, 8'd127},
    '{64'h20,                             8'd0, 8'd24}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  // wait for output register to take the current state
  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic out_chk(input string req, input logic [7:0] l, input logic [7:0] v);
    check(req, {24'd0, irq_level}, {24'd0, l});
    check(req, {24'd0, irq_vector}, {24'd0, v});
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R10 reset state
    out_chk("R10", 8'd0, 8'd24);
    rd(8'h08, d); check("R10 mask hi", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R10 mask lo", d, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    rd(8'h14, d); check("R10 force lo", d, 32'h0);
    rd(8'h7F, d); check("R10 ctl63", d, 32'h0);
    rd(8'hE0, d); check("R10 vector", d, 32'd24);

    // configure levels; R5 control-byte writes
    wr(8'h40, 32'd2);  wr(8'h43, 32'd5);  wr(8'h4A, 32'd5);
    wr(8'h54, 32'd7);  wr(8'h7F, 32'd1);  wr(8'h68, 32'd0);
    wr(8'h1D, 32'h40);              // R8 clear all
    rd(8'h08, d); check("R8 clear all hi", d, 32'h0);

    // R1 R2 R3 R11 table walk: one edge from irq_in to outputs (R4)
    foreach (TABLE[i]) begin
      @(negedge clk);
      irq_in = TABLE[i].irq;
      rd(8'h04, d); check("R11 pending lo", d, TABLE[i].irq[31:0]);
      @(negedge clk);
      out_chk("R2 R3 table", TABLE[i].lvl, TABLE[i].vec);
    end

    // R4 write takes effect one edge after the write edge
    irq_in = 64'h0010_0008;
    settle();
    out_chk("R2", 8'd7, 8'd84);
    wr(8'h1C, 32'd20);              // R7 mask bit 20
    out_chk("R4 before", 8'd7, 8'd84);
    settle();
    out_chk("R7 single set", 8'd5, 8'd67);
    rd(8'h0C, d); check("R7 mask lo", d, 32'h0010_0000);
    wr(8'h1D, 32'd20);              // R8 single clear
    settle();
    out_chk("R8 single clear", 8'd7, 8'd84);

    // R6 mask high half
    irq_in = 64'h8000_0000_0000_0000;
    wr(8'h08, 32'h8000_0000);
    settle();
    out_chk("R6 mask hi", 8'd0, 8'd24);
    rd(8'h0C, d); check("R6 lo kept", d, 32'h0);
    wr(8'h0C, 32'h0000_0001);
    rd(8'h08, d); check("R6 hi kept", d, 32'h8000_0000);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R6 pending write ignored", d, 32'h0);
    rd(8'h0C, d); check("R6 unmapped write ignored", d, 32'h1);
    rd(8'h14, d); check("R6 force untouched", d, 32'h0);

    // R9 force, vector readback, unmapped read
    irq_in = '0;
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'h8);
    settle();
    out_chk("R9 force", 8'd5, 8'd67);
    rd(8'h14, d); check("R9 force lo", d, 32'h8);
    rd(8'hE0, d); check("R9 vector read", d, 32'd67);
    rd(8'h30, d); check("R9 unmapped read", d, 32'h0);
    wr(8'h14, 32'h0);

    // R5 data[7:0] only; zero byte disables
    wr(8'h4B, 32'h1234_5609);
    rd(8'h4B, d); check("R5 byte", d, 32'h9);
    irq_in = 64'h0010_0000;
    settle();
    out_chk("R5 enabled", 8'd7, 8'd84);
    wr(8'h54, 32'h0);
    settle();
    out_chk("R5 disabled", 8'd0, 8'd24);

    // R7 set all
    wr(8'h54, 32'd7);
    wr(8'h1C, 32'h40);
    settle();
    out_chk("R7 set all", 8'd0, 8'd24);
    rd(8'h08, d); check("R7 mask all", d, 32'hFFFF_FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule